// File: doc/BRIEF.md
# Polyphase Scaler Coefficient Store

This block keeps the filter coefficients used by a video scaler that has four taps per filter and sixty-four phases. There are four independent filter sets, selected by a 2-bit kind code: 0 is vertical luma, 1 is vertical chroma, 2 is horizontal luma and 3 is horizontal chroma. A host loads the store in two steps. It first loads an address register with a kind, a phase and a tap-pair number. It then issues data writes. Each data write carries two coefficients, each with its own lane enable.

Only phases 0 to 32 are stored. A lookup for a phase above 32 is served from the stored partner phase (64 minus the phase), with the tap order reversed. The storage is held twice. Host writes always go to the shadow copy. A commit strobe exchanges the shadow and live copies on a single clock edge. This lets a full reload be prepared while the scaler keeps reading a coherent set. The lookup port returns all four taps of the requested kind and phase, one cycle after the request.

Top module: `pcoef_store`

## Requirements
- R1: After reset every coefficient of both copies reads as zero, and copy 0 is the live copy.
- R2: The address register (kind, phase, pair) loads only on a cycle with `sel_we` high and holds otherwise. A data write uses the address held before its own edge, even when `sel_we` is high in the same cycle.
- R3: A data write to pair p places `dat_even` in tap 2p and `dat_odd` in tap 2p+1 of the addressed kind and phase in the shadow copy, and touches no other entry.
- R4: A lane whose enable is low leaves its stored tap unchanged. This covers an odd tap count, where the last pair is written with only the even lane.
- R5: A data write whose addressed phase is above 32 changes no stored coefficient.
- R6: Shadow writes are not visible on the lookup port until a commit.
- R7: With `upd_commit` high on an edge, the copies are exchanged on that edge. A lookup sampled on that edge still returns the old live data. A data write on that edge lands in the copy that becomes live.
- R8: A lookup of phase 0 to 32 returns the stored taps of that phase in order on `lk_coef`, with tap k in bits [16k+15:16k], one clock after the request.
- R9: A lookup of phase 33 to 63 returns stored phase 64 minus the phase, with output tap k taken from stored tap 3 minus k.
- R10: The four filter kinds are stored separately. A write to one kind never changes another.
- R11: After a commit, the new shadow copy keeps the contents it had as the former live copy. It is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Load the address register |
| sel_kind | input | 2 | Filter kind to address |
| sel_phase | input | 6 | Phase to address |
| sel_pair | input | 1 | Tap pair to address |
| dat_we | input | 1 | Data write strobe |
| dat_even_en | input | 1 | Even lane enable |
| dat_even | input | 16 | Even tap coefficient |
| dat_odd_en | input | 1 | Odd lane enable |
| dat_odd | input | 16 | Odd tap coefficient |
| upd_commit | input | 1 | Exchange shadow and live copies |
| lk_kind | input | 2 | Lookup filter kind |
| lk_phase | input | 6 | Lookup phase 0 to 63 |
| lk_coef | output | 64 | Four taps of the looked-up phase |

## Verification
The bench loads a full vertical-luma set in which every value encodes its kind, phase, tap and load generation. It then sweeps all sixty-four phases, so a wrong fold index or a missing tap reversal shows up as a value from the wrong phase or tap. Single-lane writes separate the even and odd enables. A write addressed to phase 40 checks the out-of-range guard. Lookups taken before, during and after a commit, with a write issued on the commit edge, pin down the exact edge on which the copies exchange. Address-register changes without `sel_we`, and a `sel_we` in the same cycle as a data write, check which address a write uses. A second-generation load, followed by a further commit, checks that the former live copy's contents survive in the new shadow copy.

// File: rtl/pcoef_pkg.sv
package pcoef_pkg;
  // Filter kind codes used on both the host and lookup sides.
  typedef enum logic [1:0] {
    KIND_LUMA_V   = 2'd0,
    KIND_CHROMA_V = 2'd1,
    KIND_LUMA_H   = 2'd2,
    KIND_CHROMA_H = 2'd3
  } coef_kind_e;

  localparam int KIND_W      = 2;
  localparam int NUM_KINDS   = 4;
  localparam int DEF_TAPS    = 4;
  localparam int DEF_PHASES  = 64;
  localparam int DEF_COEF_W  = 16;
endpackage

// File: rtl/pcoef_select.sv
module pcoef_select #(
  parameter int KIND_W = 2,
  parameter int PH_W   = 6,
  parameter int PAIR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [KIND_W-1:0] sel_kind,
  input  logic [PH_W-1:0]   sel_phase,
  input  logic [PAIR_W-1:0] sel_pair,
  output logic [KIND_W-1:0] cur_kind,
  output logic [PH_W-1:0]   cur_phase,
  output logic [PAIR_W-1:0] cur_pair
);
  logic [KIND_W-1:0] kind_q, kind_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [PAIR_W-1:0] pair_q, pair_d;

  always_comb begin
    kind_d  = sel_kind;
    phase_d = sel_phase;
    pair_d  = sel_pair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= '0;
      phase_q <= '0;
      pair_q  <= '0;
    end else if (sel_we) begin
      kind_q  <= kind_d;
      phase_q <= phase_d;
      pair_q  <= pair_d;
    end
  end

  assign cur_kind  = kind_q;
  assign cur_phase = phase_q;
  assign cur_pair  = pair_q;

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable({kind_q, phase_q, pair_q})); // R2
endmodule

// File: rtl/pcoef_banks.sv
module pcoef_banks #(
  parameter int NUM_KINDS  = 4,
  parameter int NUM_STORED = 33,
  parameter int NUM_TAPS   = 4,
  parameter int COEF_W     = 16,
  parameter int KIND_W     = 2,
  parameter int PH_W       = 6,
  parameter int PAIR_W     = 1,
  localparam int NUM_CELLS = 2 * NUM_KINDS * NUM_STORED * NUM_TAPS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_fire,
  input  logic [KIND_W-1:0]          wr_kind,
  input  logic [PH_W-1:0]            wr_phase,
  input  logic [PAIR_W-1:0]          wr_pair,
  input  logic                       ev_en,
  input  logic [COEF_W-1:0]          ev_coef,
  input  logic                       od_en,
  input  logic [COEF_W-1:0]          od_coef,
  input  logic                       commit,
  input  logic [KIND_W-1:0]          rd_kind,
  input  logic [PH_W-1:0]            rd_phase,
  output logic [NUM_TAPS*COEF_W-1:0] rd_taps
);
  logic active_q, active_d;
  logic shadow;
  logic [NUM_CELLS-1:0]        cell_we;
  logic [NUM_CELLS*COEF_W-1:0] cells;

  assign shadow = ~active_q;

  // Live-copy selector: flips on every commit edge.
  always_comb active_d = ~active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active_q <= 1'b0;
    else if (commit) active_q <= active_d;
  end

  // One register per (copy, kind, stored phase, tap); phases above the
  // stored range match no cell and are dropped.
  for (genvar gb = 0; gb < 2; gb++) begin : g_copy
    for (genvar gf = 0; gf < NUM_KINDS; gf++) begin : g_kind
      for (genvar gs = 0; gs < NUM_STORED; gs++) begin : g_phase
        for (genvar gt = 0; gt < NUM_TAPS; gt++) begin : g_tap
          localparam int IDX = ((gb * NUM_KINDS + gf) * NUM_STORED + gs) * NUM_TAPS + gt;
          logic hit, lane_en;
          logic [COEF_W-1:0] cell_q, cell_d;

          assign hit = wr_fire && (shadow == 1'(gb)) && (wr_kind == KIND_W'(gf)) &&
                       (wr_phase == PH_W'(gs)) && (wr_pair == PAIR_W'(gt / 2));
          if ((gt % 2) == 1) begin : g_odd
            assign lane_en = hit && od_en;
            assign cell_d  = od_coef;
          end else begin : g_even
            assign lane_en = hit && ev_en;
            assign cell_d  = ev_coef;
          end

          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cell_q <= '0;
            else if (lane_en) cell_q <= cell_d;
          end

          assign cell_we[IDX] = lane_en;
          assign cells[IDX*COEF_W +: COEF_W] = cell_q;
        end
      end
    end
  end

  // Read from the live copy at the folded phase.
  int rd_base;
  always_comb begin
    rd_base = ((int'(active_q) * NUM_KINDS + int'(rd_kind)) * NUM_STORED + int'(rd_phase)) * NUM_TAPS;
    rd_taps = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      rd_taps[k*COEF_W +: COEF_W] = cells[(rd_base + k)*COEF_W +: COEF_W];
    end
  end

  AST_SWAP_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active_q != $past(active_q))); // R7
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q)); // R6
  AST_ONE_PAIR_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cell_we) <= 2); // R3
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |-> (cell_we == '0)); // R3
  AST_SHADOW_ONLY_PHASE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_phase) >= NUM_STORED) |-> (cell_we == '0)); // R5
endmodule

// File: rtl/pcoef_fold.sv
module pcoef_fold #(
  parameter int NUM_PHASES = 64,
  parameter int NUM_TAPS   = 4,
  parameter int COEF_W     = 16,
  parameter int PH_W       = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PH_W-1:0]            lk_phase,
  output logic [PH_W-1:0]            fold_phase,
  input  logic [NUM_TAPS*COEF_W-1:0] taps_in,
  output logic [NUM_TAPS*COEF_W-1:0] coef_out
);
  localparam int HALF = NUM_PHASES / 2;
  localparam logic [PH_W:0] FULL = (PH_W+1)'(NUM_PHASES);

  logic                       mirror;
  logic [PH_W:0]              diff;
  logic [NUM_TAPS*COEF_W-1:0] coef_d, coef_q;

  always_comb begin
    mirror     = int'(lk_phase) > HALF;
    diff       = FULL - {1'b0, lk_phase};
    fold_phase = mirror ? diff[PH_W-1:0] : lk_phase;
  end

  // Mirrored phases use the partner's taps in reverse order.
  always_comb begin
    coef_d = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      coef_d[k*COEF_W +: COEF_W] = mirror ? taps_in[(NUM_TAPS-1-k)*COEF_W +: COEF_W]
                                          : taps_in[k*COEF_W +: COEF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coef_q <= '0;
    else        coef_q <= coef_d;
  end

  assign coef_out = coef_q;

  AST_FOLD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fold_phase) <= HALF); // R9
  AST_LOW_PHASE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lk_phase) <= HALF) |-> (fold_phase == lk_phase)); // R8
endmodule

// File: rtl/pcoef_store.sv
module pcoef_store
  import pcoef_pkg::*;
#(
  parameter int  NUM_TAPS   = DEF_TAPS,
  parameter int  NUM_PHASES = DEF_PHASES,
  parameter int  COEF_W     = DEF_COEF_W,
  localparam int PH_W       = $clog2(NUM_PHASES),
  localparam int NUM_PAIRS  = (NUM_TAPS + 1) / 2,
  localparam int PAIR_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_we,
  input  logic [KIND_W-1:0]          sel_kind,
  input  logic [PH_W-1:0]            sel_phase,
  input  logic [PAIR_W-1:0]          sel_pair,
  input  logic                       dat_we,
  input  logic                       dat_even_en,
  input  logic [COEF_W-1:0]          dat_even,
  input  logic                       dat_odd_en,
  input  logic [COEF_W-1:0]          dat_odd,
  input  logic                       upd_commit,
  input  logic [KIND_W-1:0]          lk_kind,
  input  logic [PH_W-1:0]            lk_phase,
  output logic [NUM_TAPS*COEF_W-1:0] lk_coef
);
  localparam int NUM_STORED = NUM_PHASES / 2 + 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_q1, rst_q2, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_int_n = rst_q2;

  logic [KIND_W-1:0]          cur_kind;
  logic [PH_W-1:0]            cur_phase;
  logic [PAIR_W-1:0]          cur_pair;
  logic [PH_W-1:0]            fold_phase;
  logic [NUM_TAPS*COEF_W-1:0] live_taps;

  pcoef_select #(.KIND_W(KIND_W), .PH_W(PH_W), .PAIR_W(PAIR_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel_we    (sel_we),
    .sel_kind  (sel_kind),
    .sel_phase (sel_phase),
    .sel_pair  (sel_pair),
    .cur_kind  (cur_kind),
    .cur_phase (cur_phase),
    .cur_pair  (cur_pair)
  );

  pcoef_banks #(
    .NUM_KINDS (NUM_KINDS), .NUM_STORED(NUM_STORED), .NUM_TAPS(NUM_TAPS),
    .COEF_W    (COEF_W),    .KIND_W    (KIND_W),     .PH_W    (PH_W),
    .PAIR_W    (PAIR_W)
  ) u_banks (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_fire  (dat_we),
    .wr_kind  (cur_kind),
    .wr_phase (cur_phase),
    .wr_pair  (cur_pair),
    .ev_en    (dat_even_en),
    .ev_coef  (dat_even),
    .od_en    (dat_odd_en),
    .od_coef  (dat_odd),
    .commit   (upd_commit),
    .rd_kind  (lk_kind),
    .rd_phase (fold_phase),
    .rd_taps  (live_taps)
  );

  pcoef_fold #(
    .NUM_PHASES(NUM_PHASES), .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W), .PH_W(PH_W)
  ) u_fold (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lk_phase   (lk_phase),
    .fold_phase (fold_phase),
    .taps_in    (live_taps),
    .coef_out   (lk_coef)
  );
endmodule

// File: tb/pcoef_store_test.sv
`timescale 1ns/1ps
module pcoef_store_test;
  localparam int NT = 4;
  localparam int CW = 16;
  localparam int NS = 33;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_we, dat_we, dat_even_en, dat_odd_en, upd_commit;
  logic [1:0] sel_kind, lk_kind;
  logic [5:0] sel_phase, lk_phase;
  logic [0:0] sel_pair;
  logic [CW-1:0] dat_even, dat_odd;
  logic [NT*CW-1:0] lk_coef;

  int n_chk = 0;
  int n_bad = 0;

  // Reference model: two copies, live selector, held address.
  logic [CW-1:0] model [2][4][NS][NT];
  logic act;
  int m_kind, m_phase, m_pair;

  always #10 clk = ~clk;

  pcoef_store uut (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_kind(sel_kind),
    .sel_phase(sel_phase), .sel_pair(sel_pair), .dat_we(dat_we),
    .dat_even_en(dat_even_en), .dat_even(dat_even), .dat_odd_en(dat_odd_en),
    .dat_odd(dat_odd), .upd_commit(upd_commit), .lk_kind(lk_kind),
    .lk_phase(lk_phase), .lk_coef(lk_coef)
  );

  function automatic logic [CW-1:0] pat(int t, int ph, int k, int g);
    return CW'((g % 16) * 4096 + t * 1024 + ph * 16 + k);
  endfunction

  function automatic logic [NT*CW-1:0] expect_vec(int t, int ph, logic bk);
    logic [NT*CW-1:0] v;
    for (int k = 0; k < NT; k++) begin
      if (ph <= 32) v[k*CW +: CW] = model[bk][t][ph][k];
      else          v[k*CW +: CW] = model[bk][t][64-ph][NT-1-k];
    end
    return v;
  endfunction

  task automatic compare(string tag, logic [NT*CW-1:0] got, logic [NT*CW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op_sel(int t, int ph, int pr);
    sel_we = 1'b1; sel_kind = 2'(t); sel_phase = 6'(ph); sel_pair = 1'(pr);
    @(negedge clk);
    sel_we = 1'b0;
    m_kind = t; m_phase = ph; m_pair = pr;
  endtask

  task automatic op_data(logic ee, logic [CW-1:0] ev, logic oe, logic [CW-1:0] od, logic cm);
    logic sb;
    dat_we = 1'b1; dat_even_en = ee; dat_even = ev; dat_odd_en = oe; dat_odd = od;
    upd_commit = cm;
    sb = ~act;
    if (m_phase <= 32) begin
      if (ee) model[sb][m_kind][m_phase][2*m_pair]   = ev;
      if (oe) model[sb][m_kind][m_phase][2*m_pair+1] = od;
    end
    if (cm) act = ~act;
    @(negedge clk);
    dat_we = 1'b0; dat_even_en = 1'b0; dat_odd_en = 1'b0; upd_commit = 1'b0;
  endtask

  task automatic op_commit();
    upd_commit = 1'b1;
    act = ~act;
    @(negedge clk);
    upd_commit = 1'b0;
  endtask

  task automatic load_kind(int t, int g);
    for (int ph = 0; ph < NS; ph++) begin
      for (int pr = 0; pr < 2; pr++) begin
        op_sel(t, ph, pr);
        op_data(1'b1, pat(t, ph, 2*pr, g), 1'b1, pat(t, ph, 2*pr+1, g), 1'b0);
      end
    end
  endtask

  task automatic check_lookup(int t, int ph, string tag);
    lk_kind = 2'(t); lk_phase = 6'(ph);
    @(negedge clk);
    compare($sformatf("%s kind %0d phase %0d", tag, t, ph), lk_coef, expect_vec(t, ph, act));
  endtask

  // R1: everything reads zero after reset
  task automatic t_reset();
    for (int t = 0; t < 4; t++) begin
      check_lookup(t, 0, "R1");
      check_lookup(t, 32, "R1");
      check_lookup(t, 47, "R1");
    end
  endtask

  // R6 then R8/R9 over the full phase range
  task automatic t_load_and_sweep();
    load_kind(0, 1);
    check_lookup(0, 5, "R6 shadow hidden");
    check_lookup(0, 50, "R6 shadow hidden");
    op_commit();
    for (int ph = 0; ph < 64; ph++) begin
      if (ph <= 32) check_lookup(0, ph, "R8");
      else          check_lookup(0, ph, "R9");
    end
  endtask

  // R10 and R11: another kind in the other copy
  task automatic t_kinds_retain();
    load_kind(3, 2);
    op_commit();
    check_lookup(3, 9, "R10");
    check_lookup(3, 55, "R10");
    check_lookup(0, 9, "R11 former copy kept");
    check_lookup(1, 9, "R10");
    op_sel(2, 4, 0);
    op_data(1'b1, 16'h1357, 1'b1, 16'h2468, 1'b0);
    op_commit();
    check_lookup(0, 9, "R11 former copy kept");
    check_lookup(0, 40, "R11 former copy kept");
    check_lookup(2, 4, "R3");
    check_lookup(3, 9, "R11 older copy content");
  endtask

  // R4: single lane enables
  task automatic t_lanes();
    op_sel(0, 7, 1);
    op_data(1'b1, 16'hAAAA, 1'b0, 16'h5555, 1'b0);
    op_sel(0, 8, 0);
    op_data(1'b0, 16'h1111, 1'b1, 16'h2222, 1'b0);
    op_commit();
    check_lookup(0, 7, "R4 even only");
    check_lookup(0, 57, "R4 even only mirrored");
    check_lookup(0, 8, "R4 odd only");
  endtask

  // R5: phase above stored range is dropped
  task automatic t_range();
    op_sel(0, 40, 0);
    op_data(1'b1, 16'hDEAD, 1'b1, 16'hBEEF, 1'b0);
    op_sel(0, 63, 1);
    op_data(1'b1, 16'hCAFE, 1'b1, 16'hF00D, 1'b0);
    op_commit();
    check_lookup(0, 24, "R5");
    check_lookup(0, 40, "R5");
    check_lookup(0, 1, "R5");
    check_lookup(0, 63, "R5");
  endtask

  // R2: address register load and hold
  task automatic t_select();
    op_sel(1, 3, 1);
    sel_kind = 2'd2; sel_phase = 6'd9; sel_pair = 1'b0;
    op_data(1'b1, 16'h0A0A, 1'b1, 16'h0B0B, 1'b0);
    // sel_we in the same cycle as the write: the write uses (1,3,1)
    sel_we = 1'b1; sel_kind = 2'd1; sel_phase = 6'd12; sel_pair = 1'b0;
    op_data(1'b1, 16'h0C0C, 1'b1, 16'h0D0D, 1'b0);
    sel_we = 1'b0;
    m_kind = 1; m_phase = 12; m_pair = 0;
    op_data(1'b1, 16'h0E0E, 1'b0, 16'h0000, 1'b0);
    op_commit();
    check_lookup(1, 3, "R2 held address");
    check_lookup(2, 9, "R2 no load without we");
    check_lookup(1, 12, "R2 loaded address");
  endtask

  // R7: commit edge behaviour
  task automatic t_commit_edge();
    logic [NT*CW-1:0] exp_old;
    op_sel(2, 0, 0);
    // lookup sampled on the commit edge still sees the old live copy
    exp_old = expect_vec(2, 0, act);
    lk_kind = 2'd2; lk_phase = 6'd0;
    op_data(1'b1, 16'h7777, 1'b1, 16'h8888, 1'b1);
    compare("R7 lookup on commit edge", lk_coef, exp_old);
    check_lookup(2, 0, "R7 write on commit edge");
    check_lookup(2, 64 - 32, "R7");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sel_we = 1'b0; sel_kind = '0; sel_phase = '0; sel_pair = '0;
    dat_we = 1'b0; dat_even_en = 1'b0; dat_even = '0; dat_odd_en = 1'b0; dat_odd = '0;
    upd_commit = 1'b0; lk_kind = '0; lk_phase = '0;
    act = 1'b0; m_kind = 0; m_phase = 0; m_pair = 0;
    for (int b = 0; b < 2; b++)
      for (int t = 0; t < 4; t++)
        for (int s = 0; s < NS; s++)
          for (int k = 0; k < NT; k++)
            model[b][t][s][k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    t_reset();
    t_load_and_sweep();
    t_kinds_retain();
    t_lanes();
    t_range();
    t_select();
    t_commit_edge();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule